// File: doc/BRIEF.md
# Buffered Dual-Edge Input Capture Unit

This block timestamps events on four input pins against a free-running counter. Each channel (A, B, C and D) has its own capture register, capture flag, edge selector and interrupt enable. In the plain mode, a channel copies the counter into its register when its pin shows the chosen edge. Its flag is then raised.

Two pairing bits link C to A and D to B. When a pair is linked, a capture on the primary pin first pushes the primary register's old value into the partner, so software sees the latest and the previous timestamp together. If the two channels of a linked pair have opposite edge selections, the primary pin captures on both edges. That setting measures high and low pulse widths.

While a pair is linked, the partner pin still raises its own flag but no longer loads the counter. A small register port gives software read access to the counter, the captures, the control word and the flags. A capture on a linked pair waits for one clock while software reads either register of that pair, so the read returns a consistent value. The register port is plain control access and has no handshake: a read returns data in the same cycle, and a write takes effect at the next clock edge.

Top module: `cap_unit`

## Requirements
- R1: The counter resets to 0 and advances by one on each clock with `cnt_en` high. It wraps from 0xFFFF to 0x0000 and holds while `cnt_en` is low. Software reads it at address 0.
- R2: After reset, all capture registers, the control word and the flags read 0, and `irq` is low.
- R3: A channel that is not linked captures on its selected edge. In the control word, bit n (n = 0..3 for A..D) set to 1 selects rising edges and 0 selects falling edges. An edge of the other polarity captures nothing. Captures are read at address 1 (A), 2 (B), 3 (C) and 4 (D). With the counter enabled every cycle, the captured value is the counter value seen in the cycle the pin changes, plus 2.
- R4: A capture sets the channel's flag. The flag byte is at address 6, with bit n for channel n. Writing 0 to a flag bit clears that flag. Writing 1 leaves it unchanged.
- R5: `irq` is high exactly when some flag is set while its enable is set. The enables are control bits 4..7 for A..D.
- R6: Control bit 8 links C to A and control bit 9 links D to B. In a linked pair, each primary capture moves the old primary value into the partner and loads the counter into the primary.
- R7: In a linked pair whose two edge selections differ, the primary pin captures on both its rising and falling edges.
- R8: In a linked pair, the selected edge on the partner pin sets the partner's flag but leaves the partner register unchanged.
- R9: If a linked pair's capture arrives while either of its two registers is being read (`reg_rd` high with that address), the capture happens one clock later. An unlinked channel captures without delay.
- R10: The control word (address 5) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| cap_pin | input | 4 | Capture pins, bit 0 = A to bit 3 = D |
| reg_rd | input | 1 | Read strobe, marks a read in progress |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a two-stage synchronizer. The 16-bit width keeps the counter's wrap within reach of a short run, and the two synchronizer stages fix the pin-to-capture latency that the bench's timing checks rely on. With that fixed latency, a register read can be placed in exactly the cycle a capture is pending. This shows the one-clock hold on a linked pair and the missing hold on an unlinked one as timestamps that differ by one.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_PAIR = 2;
  localparam int ADDR_W   = 3;
  localparam int CTRL_W   = 10;

  // register addresses; channel n capture lives at address n+1
  typedef enum logic [ADDR_W-1:0] {
    RS_COUNT = 3'd0,
    RS_CAPA  = 3'd1,
    RS_CAPB  = 3'd2,
    RS_CAPC  = 3'd3,
    RS_CAPD  = 3'd4,
    RS_CTRL  = 3'd5,
    RS_FLAG  = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic [NUM_PAIR-1:0] link;       // bit 8: C buffers A, bit 9: D buffers B
    logic [NUM_CH-1:0]   irq_en;     // bits 7:4
    logic [NUM_CH-1:0]   edge_rise;  // bits 3:0, 1 = rising, 0 = falling
  } ctrl_t;
endpackage

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= '0;
    else if (en) value <= value + 1'b1;
  end
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/cap_pair.sv
// One primary channel plus its partner, which can act as history buffer.
module cap_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link,
  input  logic         sel_p,
  input  logic         sel_b,
  input  logic         p_rise,
  input  logic         p_fall,
  input  logic         b_rise,
  input  logic         b_fall,
  input  logic         rd_hit,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] p_q,
  output logic [W-1:0] b_q,
  output logic         p_set,
  output logic         b_set,
  output logic         go
);
  logic pend_q;
  logic p_own, p_alt, b_ev, req, stall;

  assign p_own = sel_p ? p_rise : p_fall;
  assign p_alt = sel_b ? p_rise : p_fall;   // partner's edge choice applied to primary pin
  assign b_ev  = sel_b ? b_rise : b_fall;

  assign req   = link ? (p_own | p_alt | pend_q) : p_own;
  assign stall = link & rd_hit;
  assign go    = req & ~stall;

  assign p_set = go;
  assign b_set = b_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      p_q    <= '0;
      b_q    <= '0;
    end else begin
      pend_q <= link & req & stall;
      if (go) begin
        p_q <= cnt;
        if (link) b_q <= p_q;
      end
      if (!link && b_ev) b_q <= cnt;
    end
  end
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [NUM_CH-1:0] cap_pin,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_CH-1:0]            rise, fall, set_pulse, flag_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_q;
  logic [NUM_PAIR-1:0]          pair_go, rd_hit;
  ctrl_t                        ctrl_q;

  cap_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .value(cnt_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_edge
    cap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]), .rise(rise[c]), .fall(fall[c])
    );
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int B = p + NUM_PAIR;
    assign rd_hit[p] = reg_rd && ((reg_addr == ADDR_W'(p + 1)) || (reg_addr == ADDR_W'(B + 1)));
    cap_pair #(.W(CNT_W)) u_pair (
      .clk(clk), .rst_n(rst_n),
      .link(ctrl_q.link[p]),
      .sel_p(ctrl_q.edge_rise[p]), .sel_b(ctrl_q.edge_rise[B]),
      .p_rise(rise[p]), .p_fall(fall[p]), .b_rise(rise[B]), .b_fall(fall[B]),
      .rd_hit(rd_hit[p]), .cnt(cnt_q),
      .p_q(cap_q[p]), .b_q(cap_q[B]),
      .p_set(set_pulse[p]), .b_set(set_pulse[B]), .go(pair_go[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_wr && reg_addr == RS_CTRL) begin
      ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (set_pulse[c])                                        flag_q[c] <= 1'b1;
        else if (reg_wr && reg_addr == RS_FLAG && !reg_wdata[c]) flag_q[c] <= 1'b0;
      end
    end
  end

  assign irq = |(flag_q & ctrl_q.irq_en);

  always_comb begin
    case (reg_sel_e'(reg_addr))
      RS_COUNT: reg_rdata = cnt_q;
      RS_CAPA:  reg_rdata = cap_q[0];
      RS_CAPB:  reg_rdata = cap_q[1];
      RS_CAPC:  reg_rdata = cap_q[2];
      RS_CAPD:  reg_rdata = cap_q[3];
      RS_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      RS_FLAG:  reg_rdata = CNT_W'(flag_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [W-1:0]      cnt,
  input logic [1:0]        link,
  input logic [1:0]        go,
  input logic [1:0]        rd_hit,
  input logic [3:0][W-1:0] cap,
  input logic [3:0]        flags
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == W'($past(cnt) + 1'b1));

  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  for (genvar p = 0; p < 2; p++) begin : g_pair_chk
    a_r6_old_to_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      (link[p] && go[p]) |=> cap[p+2] == $past(cap[p]));

    a_r8_buffer_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (link[p] && !go[p]) |=> $stable(cap[p+2]));

    a_r9_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (link[p] && rd_hit[p]) |=> $stable(cap[p]));

    a_r4_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
      go[p] |=> flags[p]);
  end
endmodule

bind cap_unit cap_unit_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt_q),
  .link(ctrl_q.link), .go(pair_go), .rd_hit(rd_hit),
  .cap(cap_q), .flags(flag_q)
);

// File: tb/cap_unit_tb.sv
module cap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [3:0]  cap_pin = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [15:0] cnt_m = '0;
  logic [15:0] cap_m [4];
  logic [3:0]  flag_m = '0, sel_m = '0, ie_m = '0, pin_m = '0;
  logic [1:0]  link_m = '0;

  // vector: {ch[1:0], sel, level, advance[15:0]}
  localparam logic [19:0] VEC [8] = '{
    20'h3_0010, 20'h2_0005, 20'h5_0003, 20'h4_0007,
    20'hB_0100, 20'hF_0022, 20'hC_0001, 20'h8_0040
  };

  always #10 clk = ~clk;

  cap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_pin(cap_pin),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic wr_ctrl();
    wr(3'd5, {6'd0, link_m, ie_m, sel_m});
  endtask

  task automatic advance(input int n);
    if (n > 0) begin
      @(negedge clk); cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 cnt_en = 1'b0;
      cnt_m = cnt_m + 16'(n);
    end
  endtask

  // model of one pin transition with the counter static
  task automatic model_edge(input int ch, input logic lvl);
    if (pin_m[ch] != lvl) begin
      if (ch < 2) begin
        if (link_m[ch]) begin
          if (lvl == sel_m[ch] || lvl == sel_m[ch+2]) begin
            cap_m[ch+2] = cap_m[ch]; cap_m[ch] = cnt_m; flag_m[ch] = 1'b1;
          end
        end else if (lvl == sel_m[ch]) begin
          cap_m[ch] = cnt_m; flag_m[ch] = 1'b1;
        end
      end else if (lvl == sel_m[ch]) begin
        flag_m[ch] = 1'b1;
        if (!link_m[ch-2]) cap_m[ch] = cnt_m;
      end
    end
    pin_m[ch] = lvl;
  endtask

  task automatic pin_set(input int ch, input logic lvl);
    @(negedge clk); cap_pin[ch] = lvl;
    repeat (5) @(posedge clk); #1;
    model_edge(ch, lvl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, v, old_a;
    for (int i = 0; i < 4; i++) cap_m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d); check("R2 reset register", d, 16'h0);
    end
    check("R2 reset irq", {15'd0, irq}, 16'h0);

    // R3/R4 table walk, unlinked channels
    for (int i = 0; i < 8; i++) begin
      int ch;
      ch = int'(VEC[i][19:18]);
      sel_m[ch] = VEC[i][17];
      wr_ctrl();
      advance(int'(VEC[i][15:0]));
      pin_set(ch, VEC[i][16]);
      rd(3'(ch + 1), d); check("R3 capture value", d, cap_m[ch]);
      rd(3'd6, d);       check("R4 flags after capture", d, {12'd0, flag_m});
    end

    // R4 clear by writing 0, writing 1 keeps
    wr(3'd6, 16'h000A); flag_m = flag_m & 4'hA;
    rd(3'd6, d); check("R4 flag clear", d, {12'd0, flag_m});

    // R5 interrupt
    check("R5 irq off with no enable", {15'd0, irq}, 16'h0);
    ie_m = 4'b0010; wr_ctrl(); #2;
    check("R5 irq on flag B enabled", {15'd0, irq}, 16'h1);
    wr(3'd6, 16'h0008); flag_m = flag_m & 4'h8; #2;
    check("R5 irq off after flag B cleared", {15'd0, irq}, 16'h0);
    wr(3'd6, 16'h0000); flag_m = '0;

    // R10 control readback
    rd(3'd5, d); check("R10 control readback", d, {6'd0, link_m, ie_m, sel_m});

    // R3 latency: pin A rising (sel A = 1), counter running
    @(negedge clk);
    cnt_en = 1'b1; reg_rd = 1'b1; reg_addr = 3'd0; cap_pin[0] = 1'b1;
    #2 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
    repeat (4) @(posedge clk); #1 cnt_en = 1'b0;
    rd(3'd0, cnt_m);
    cap_m[0] = v + 16'd2; pin_m[0] = 1'b1; flag_m[0] = 1'b1;
    rd(3'd1, d); check("R3 latency value", d, cap_m[0]);

    // R6/R7 link C to A, opposite edges
    link_m[0] = 1'b1; sel_m[0] = 1'b1; sel_m[2] = 1'b0; wr_ctrl();
    advance(16'h33);
    old_a = cap_m[0];
    pin_set(0, 1'b0);
    rd(3'd1, d); check("R7 falling edge captured", d, cnt_m);
    rd(3'd3, d); check("R6 old A moved to C", d, old_a);
    advance(16'h11);
    old_a = cap_m[0];
    pin_set(0, 1'b1);
    rd(3'd1, d); check("R7 rising edge captured", d, cnt_m);
    rd(3'd3, d); check("R6 second shift into C", d, old_a);

    // R8 partner pin: flag only
    wr(3'd6, 16'h0000); flag_m = '0;
    advance(16'h20);
    pin_set(2, 1'b1);
    pin_set(2, 1'b0);
    rd(3'd6, d); check("R8 partner flag set", d, 16'h0004);
    rd(3'd3, d); check("R8 partner register unchanged", d, cap_m[2]);

    // R9 linked pair: read of C during pending capture delays it
    old_a = cap_m[0];
    @(negedge clk);
    cnt_en = 1'b1; reg_rd = 1'b1; reg_addr = 3'd0; cap_pin[0] = 1'b0;
    #2 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd3;
    @(posedge clk); #1 reg_rd = 1'b0;
    @(posedge clk); #1 cnt_en = 1'b0;
    repeat (2) @(posedge clk);
    rd(3'd0, cnt_m);
    cap_m[2] = old_a; cap_m[0] = v + 16'd3; pin_m[0] = 1'b0; flag_m[0] = 1'b1;
    rd(3'd1, d); check("R9 delayed capture value", d, cap_m[0]);
    rd(3'd3, d); check("R9 delayed shift into C", d, cap_m[2]);

    // R9 unlinked pair B: read during capture has no effect on timing
    sel_m[1] = 1'b1; wr_ctrl();
    @(negedge clk);
    cnt_en = 1'b1; reg_rd = 1'b1; reg_addr = 3'd0; cap_pin[1] = 1'b1;
    #2 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd2;
    @(posedge clk); #1 reg_rd = 1'b0;
    @(posedge clk); #1 cnt_en = 1'b0;
    repeat (2) @(posedge clk);
    rd(3'd0, cnt_m);
    cap_m[1] = v + 16'd2; pin_m[1] = 1'b1;
    rd(3'd2, d); check("R9 unlinked capture not delayed", d, cap_m[1]);
    rd(3'd4, d); check("R9 D untouched", d, cap_m[3]);

    // R1 wrap
    advance(int'(16'hFFFF - cnt_m));
    rd(3'd0, d); check("R1 counter at top", d, 16'hFFFF);
    rd(3'd0, d); check("R1 counter holds", d, 16'hFFFF);
    advance(1);
    rd(3'd0, d); check("R1 counter wraps", d, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule